// File: doc/BRIEF.md
# I2C Byte-Memory Target Controller

This block is the bus-facing controller of a serial byte memory of 4096 locations. It watches an I2C clock and data pair that have already been brought into the system clock domain. It finds bus START and STOP conditions and answers to a 7-bit target address made of a fixed family code and three strap pins. It then carries out byte and page writes, current-address reads, random reads and sequential reads. It drives the data line only by pulling it low, through an output-enable.

Writes are not stored here. Each acknowledged data byte is handed to a separate page-buffer and write-engine block as a one-cycle load strobe that carries an address and a byte. A STOP after the data ends the session with a one-cycle commit strobe. While that engine reports busy, the controller ignores its own address, so a bus master can poll for completion. Reads use a synchronous read port of the array that returns data one clock after the address is presented.

A single internal pointer serves both directions. The write path steps it inside a 32-byte page. The read path steps it across the whole array.

Top module: `i2cmem_target`

## Requirements
- R1: The controller never pulls SDA low until it has seen a START, meaning SDA falling while SCL is high. Any STOP, meaning SDA rising while SCL is high, returns it to the idle state. Out of reset `sda_oe`, `ld_valid` and `commit` are 0.
- R2: After a START, the first byte is taken MSB first on rising SCL edges. Bits 7..4 must be 1010, bits 3..1 must equal `dev_sel[2:0]`, and bit 0 selects read (1) or write (0). On a match the controller pulls SDA low for the ninth clock. On any other value it leaves SDA released and ignores the bus until the next START or STOP.
- R3: While `busy_i` is high, a matching address byte is not acknowledged.
- R4: In a write, the two bytes after the address byte form the word address, high byte first. Bits 7..4 of the high byte are ignored. Both bytes are acknowledged.
- R5: Each acknowledged data byte produces exactly one `ld_valid` pulse carrying the target address and the byte. `ld_first` is high on the first pulse of a session. `ld_valid` and `commit` never occur in the same cycle.
- R6: During a write, the address for successive data bytes increments within an aligned 32-byte page, wrapping from the page's last byte back to its first.
- R7: A STOP received after at least one acknowledged data byte gives one `commit` pulse. A STOP after only the address bytes gives none.
- R8: `wp_i` is sampled on the SCL falling edge that ends the acknowledge of the low address byte. If it is high, the first data byte is not acknowledged, no load or commit is issued, and the memory is unchanged.
- R9: A read that directly follows a START returns the byte at the internal pointer. The pointer always rests one past the last byte read or written.
- R10: A random read, made of a write address phase, a repeated START and a read address byte, returns data starting at the given word address.
- R11: In a read, each sent byte advances the pointer by one, wrapping from 4095 to 0. A master no-acknowledge ends transmission and SDA stays released.
- R12: `sda_oe` changes only in the cycle after an SCL falling edge, or after a START or STOP.
- R13: A START seen in the middle of a write session abandons it. Bytes loaded in that session are never committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_sel | input | 3 | Strap pins compared with address bits 3..1 |
| wp_i | input | 1 | Write protect, active high |
| busy_i | input | 1 | Write engine busy with an internal write |
| ld_valid | output | 1 | One-cycle load of a data byte into the page buffer |
| ld_first | output | 1 | Marks the first load of a write session |
| ld_addr | output | ADDR_W | Array address of the loaded byte |
| ld_data | output | 8 | Loaded byte |
| commit | output | 1 | One-cycle request to write the loaded page |
| rd_addr | output | ADDR_W | Read-port address (the internal pointer) |
| rd_data | input | 8 | Read-port data, valid one clock after rd_addr |

## Verification
Writes are tried as one byte, as three bytes that cross a page end, and with the high-address nibble set. These patterns separate in-page wrap from full-array increment and show that the nibble is dropped. Reads are tried as current-address, random, and sequential across the top of the array. This exposes whether the pointer lands one past the last byte and whether the full-array wrap is used. Negative patterns include clocking before any START, a wrong strap value, polling during busy, write protect, an address-only write and a START mid-byte. Each must leave the loads, commits and memory contents untouched.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam logic [3:0] FAMILY_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_HI, ST_ACK_HI, ST_LO, ST_ACK_LO,
    ST_WDATA, ST_ACK_DATA, ST_RDATA, ST_RACK, ST_WAIT
  } tgt_state_t;

  // full-array increment with wrap to zero
  function automatic logic [31:0] seq_next(input logic [31:0] a, input int aw);
    logic [31:0] m;
    m = (32'd1 << aw) - 32'd1;
    return (a + 32'd1) & m;
  endfunction

  // increment inside an aligned page of 2**pw bytes
  function automatic logic [31:0] page_next(input logic [31:0] a, input int pw);
    logic [31:0] m;
    m = (32'd1 << pw) - 32'd1;
    return (a & ~m) | ((a + 32'd1) & m);
  endfunction
endpackage

// File: rtl/i2cmem_bus_events.sv
module i2cmem_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign ev_rise  = scl_i & ~scl_q;
  assign ev_fall  = ~scl_i & scl_q;
  assign ev_start = scl_i & scl_q & sda_q & ~sda_i;
  assign ev_stop  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cmem_addr_ptr.sv
module i2cmem_addr_ptr
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              step_seq,
  input  logic              step_page,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic [HI_W-1:0] hi_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stage <= '0;
      ptr      <= '0;
    end else begin
      if (hi_we) hi_stage <= byte_in[HI_W-1:0];
      if (lo_we)
        ptr <= {hi_stage, byte_in};
      else if (step_seq)
        ptr <= ADDR_W'(seq_next(32'(ptr), ADDR_W));
      else if (step_page)
        ptr <= ADDR_W'(page_next(32'(ptr), PAGE_W));
    end
  end
endmodule

// File: rtl/i2cmem_tgt_fsm.sv
module i2cmem_tgt_fsm
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  dev_sel,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              hi_we,
  output logic              lo_we,
  output logic              step_seq,
  output logic              step_page,
  output logic [BYTE_W-1:0] byte_out,
  output logic              ld_valid,
  output logic              ld_first,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [BYTE_W-1:0] ld_data,
  output logic              commit,
  output logic              dev_ack,
  output logic              fsm_idle
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  tgt_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              rw, have_data, wp_lat, mack;
  logic              addr_hit, in_write, rx_state;

  assign addr_hit = (shreg[BYTE_W-1:1] == {FAMILY_CODE, dev_sel});
  assign in_write = (state == ST_WDATA) || (state == ST_ACK_DATA);
  assign rx_state = (state == ST_DEV) || (state == ST_HI) ||
                    (state == ST_LO)  || (state == ST_WDATA);
  assign byte_out = shreg;
  assign fsm_idle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      rw        <= 1'b0;
      have_data <= 1'b0;
      wp_lat    <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      hi_we     <= 1'b0;
      lo_we     <= 1'b0;
      step_seq  <= 1'b0;
      step_page <= 1'b0;
      ld_valid  <= 1'b0;
      ld_first  <= 1'b0;
      ld_addr   <= '0;
      ld_data   <= '0;
      commit    <= 1'b0;
      dev_ack   <= 1'b0;
    end else begin
      hi_we     <= 1'b0;
      lo_we     <= 1'b0;
      step_seq  <= 1'b0;
      step_page <= 1'b0;
      ld_valid  <= 1'b0;
      ld_first  <= 1'b0;
      commit    <= 1'b0;
      dev_ack   <= 1'b0;
      if (ev_start) begin
        state     <= ST_DEV;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        have_data <= 1'b0;
      end else if (ev_stop) begin
        if (in_write && have_data) commit <= 1'b1;
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        have_data <= 1'b0;
      end else if (rx_state) begin
        if (ev_rise) begin
          shreg <= {shreg[BYTE_W-2:0], sda_i};
          cnt   <= cnt + 1'b1;
        end else if (ev_fall && cnt == LAST_BIT) begin
          unique case (state)
            ST_DEV: begin
              if (addr_hit && !busy_i) begin
                sda_oe  <= 1'b1;
                rw      <= shreg[0];
                dev_ack <= 1'b1;
                state   <= ST_ACK_DEV;
              end else begin
                state <= ST_WAIT;
              end
            end
            ST_HI: begin
              sda_oe <= 1'b1;
              hi_we  <= 1'b1;
              state  <= ST_ACK_HI;
            end
            ST_LO: begin
              sda_oe <= 1'b1;
              lo_we  <= 1'b1;
              state  <= ST_ACK_LO;
            end
            default: begin
              if (wp_lat) begin
                state <= ST_WAIT;
              end else begin
                sda_oe    <= 1'b1;
                ld_valid  <= 1'b1;
                ld_first  <= !have_data;
                ld_addr   <= ptr;
                ld_data   <= shreg;
                step_page <= 1'b1;
                have_data <= 1'b1;
                state     <= ST_ACK_DATA;
              end
            end
          endcase
        end
      end else begin
        unique case (state)
          ST_ACK_DEV: if (ev_fall) begin
            cnt <= '0;
            if (rw) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              state  <= ST_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_HI;
            end
          end
          ST_ACK_HI: if (ev_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_LO;
          end
          ST_ACK_LO: if (ev_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            wp_lat <= wp_i;
            state  <= ST_WDATA;
          end
          ST_ACK_DATA: if (ev_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WDATA;
          end
          ST_RDATA: begin
            if (ev_rise) begin
              cnt <= cnt + 1'b1;
            end else if (ev_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe   <= 1'b0;
                step_seq <= 1'b1;
                state    <= ST_RACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (ev_rise) begin
              mack <= ~sda_i;
            end else if (ev_fall) begin
              if (mack) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= '0;
                state  <= ST_RDATA;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              ld_valid,
  output logic              ld_first,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [7:0]        ld_data,
  output logic              commit,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  logic ev_rise, ev_fall, ev_start, ev_stop;
  logic hi_we, lo_we, step_seq, step_page;
  logic dev_ack, fsm_idle;
  logic [7:0] byte_out;
  logic [ADDR_W-1:0] ptr;

  i2cmem_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .ev_rise(ev_rise), .ev_fall(ev_fall), .ev_start(ev_start), .ev_stop(ev_stop)
  );

  i2cmem_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .lo_we(lo_we), .byte_in(byte_out),
    .step_seq(step_seq), .step_page(step_page), .ptr(ptr)
  );

  i2cmem_tgt_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop), .sda_i(sda_i), .dev_sel(dev_sel),
    .wp_i(wp_i), .busy_i(busy_i), .ptr(ptr), .rd_data(rd_data), .sda_oe(sda_oe),
    .hi_we(hi_we), .lo_we(lo_we), .step_seq(step_seq), .step_page(step_page),
    .byte_out(byte_out), .ld_valid(ld_valid), .ld_first(ld_first),
    .ld_addr(ld_addr), .ld_data(ld_data), .commit(commit), .dev_ack(dev_ack),
    .fsm_idle(fsm_idle)
  );

  assign rd_addr = ptr;
endmodule

// File: rtl/i2cmem_target_chk.sv
module i2cmem_target_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic ev_fall,
  input logic ev_start,
  input logic ev_stop,
  input logic fsm_idle,
  input logic dev_ack,
  input logic busy_i,
  input logic ld_valid,
  input logic commit
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !sda_oe);

  p_no_ack_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> !$past(busy_i));

  p_load_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> sda_oe);

  p_load_commit_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_valid, commit}));

  p_commit_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(ev_stop));

  p_oe_after_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(ev_fall) || $past(ev_start) || $past(ev_stop)));
endmodule

bind i2cmem_target i2cmem_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .ev_fall(ev_fall),
  .ev_start(ev_start), .ev_stop(ev_stop), .fsm_idle(fsm_idle),
  .dev_ack(dev_ack), .busy_i(busy_i), .ld_valid(ld_valid), .commit(commit)
);

// File: tb/tb_i2cmem_target.sv
module tb_i2cmem_target;
  localparam int CLK_P = 10;
  localparam int Q = 8;
  localparam int BUSY_CYC = 400;
  localparam int AW = 12;
  localparam logic [7:0] DW = 8'hAA;  // 1010_101_0
  localparam logic [7:0] DR = 8'hAB;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1;
  logic wp = 0, busy = 0;
  logic sda_oe, ld_valid, ld_first, commit;
  logic [AW-1:0] ld_addr, rd_addr;
  logic [7:0] ld_data, rd_data;
  wire sda_bus = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  i2cmem_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(3'b101), .wp_i(wp), .busy_i(busy), .ld_valid(ld_valid),
    .ld_first(ld_first), .ld_addr(ld_addr), .ld_data(ld_data), .commit(commit),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_err = 0, n_commit = 0, exp_commit = 0, bcnt = 0;
  logic [7:0] mem [4096];
  logic [7:0] exp_mem [4096];
  int exp_ptr = 0;
  int pa[$]; logic [7:0] pd[$];
  int ea[$]; logic [7:0] ed[$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // write engine and array model
  always @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (ld_valid) begin
      if (ld_first) begin pa.delete(); pd.delete(); end
      pa.push_back(int'(ld_addr)); pd.push_back(ld_data);
    end
    if (commit) begin
      busy <= 1'b1; bcnt <= BUSY_CYC;
    end else if (busy) begin
      bcnt <= bcnt - 1;
      if (bcnt == 1) begin
        foreach (pa[i]) mem[pa[i]] <= pd[i];
        pa.delete(); pd.delete();
        busy <= 1'b0;
      end
    end
  end

  // per-clock comparison of loads against the reference queue (R5, R6)
  always @(negedge clk) if (rst_n) begin
    if (commit) n_commit++;
    if (ld_valid) begin
      if (ea.size() == 0) chk(0, "R5 unexpected load", int'(ld_addr), 0);
      else begin
        chk(int'(ld_addr) == ea[0], "R6 load address", int'(ld_addr), ea[0]);
        chk(ld_data == ed[0], "R5 load data", ld_data, ed[0]);
        void'(ea.pop_front()); void'(ed.pop_front());
      end
    end
  end

  task automatic w(int n); repeat (n) @(negedge clk); endtask
  task automatic start_c(); sda_m = 1; w(Q); scl = 1; w(Q); sda_m = 0; w(Q); scl = 0; w(Q); endtask
  task automatic stop_c(); sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(Q); endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; w(Q); scl = 1; w(Q); scl = 0;
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; w(Q); scl = 1; w(Q/2); ack = !sda_bus; w(Q/2); scl = 0;
  endtask
  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1; w(Q/2); b[i] = sda_bus; w(Q/2); scl = 0;
    end
    sda_m = !mack; w(Q); scl = 1; w(Q); scl = 0; sda_m = 1;
  endtask
  task automatic wait_idle(); w(2); while (busy) w(1); w(4); endtask

  task automatic addr_phase(int a, string rq);
    bit ack;
    start_c();
    send_byte(DW, ack); chk(ack, {rq, " address ack"}, ack, 1);
    send_byte(8'hF0 | 8'(a >> 8), ack); chk(ack, "R4 high byte ack", ack, 1);
    send_byte(8'(a), ack); chk(ack, "R4 low byte ack", ack, 1);
    exp_ptr = a;
  endtask

  task automatic do_write(int a, logic [7:0] d[$]);
    bit ack;
    addr_phase(a, "R2");
    foreach (d[i]) begin
      ea.push_back(exp_ptr); ed.push_back(d[i]);
      exp_mem[exp_ptr] = d[i];
      send_byte(d[i], ack); chk(ack, "R5 data ack", ack, 1);
      exp_ptr = (exp_ptr & ~31) | ((exp_ptr + 1) & 31);
    end
    stop_c(); exp_commit++;
  endtask

  task automatic read_n(int n, string rq);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == exp_mem[exp_ptr], rq, b, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % 4096;
    end
  endtask

  task automatic cur_read(int n, string rq);
    bit ack;
    start_c(); send_byte(DR, ack); chk(ack, {rq, " read address ack"}, ack, 1);
    read_n(n, rq);
    w(2); chk(sda_oe == 0, "R11 released after no-ack", sda_oe, 0);
    stop_c();
  endtask

  task automatic rnd_read(int a, int n, string rq);
    bit ack;
    addr_phase(a, "R10");
    start_c(); send_byte(DR, ack); chk(ack, "R10 read address ack", ack, 1);
    read_n(n, rq);
    stop_c();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit ack; int polls;
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
    w(5); rst_n = 1; w(2);
    chk(sda_oe == 0 && ld_valid == 0 && commit == 0, "R1 reset outputs",
        {sda_oe, ld_valid, commit}, 0);
    // R1: a matching byte clocked with no START gets no response
    send_byte(DW, ack); chk(!ack, "R1 no START no ack", ack, 0);
    sda_m = 1; w(Q); scl = 1; w(Q);
    // R2: wrong strap value
    start_c(); send_byte(8'hA0, ack); chk(!ack, "R2 wrong select nack", ack, 0); stop_c();
    // R4 R5 R7: byte write with high nibble set
    do_write(12'h123, '{8'hA5});
    // R3: poll while the engine is busy
    start_c(); send_byte(DW, ack); chk(!ack, "R3 busy nack", ack, 0); stop_c();
    polls = 0;
    do begin
      start_c(); send_byte(DW, ack); stop_c(); polls++;
    end while (!ack && polls < 20);
    chk(ack && polls > 1, "R3 poll until ack", polls, 2);
    chk(n_commit == exp_commit, "R7 commit count after byte write", n_commit, exp_commit);
    wait_idle();
    // R10 then R9
    rnd_read(12'h123, 1, "R10 random read");
    cur_read(1, "R9 current read follows");
    // R6: page wrap, then R9 current read from one past last written
    do_write(12'h03E, '{8'hC1, 8'hC2, 8'hC3}); wait_idle();
    cur_read(1, "R9 pointer after page write");
    rnd_read(12'h020, 1, "R6 wrapped byte");
    // R8: write protect
    wp = 1;
    addr_phase(12'h050, "R8");
    send_byte(8'h77, ack); chk(!ack, "R8 protected data nack", ack, 0);
    stop_c(); wp = 0; w(4);
    chk(n_commit == exp_commit && !busy, "R8 no commit", n_commit, exp_commit);
    rnd_read(12'h050, 1, "R8 memory unchanged");
    // R7: address-only write commits nothing
    addr_phase(12'h060, "R7"); stop_c(); w(4);
    chk(n_commit == exp_commit, "R7 address-only no commit", n_commit, exp_commit);
    // R13: START mid-byte abandons a session that already loaded one byte
    addr_phase(12'h200, "R13");
    ea.push_back(12'h200); ed.push_back(8'h5A);
    send_byte(8'h5A, ack); chk(ack, "R13 first byte ack", ack, 1);
    send_bits(8'hF0, 4);
    start_c(); stop_c(); w(BUSY_CYC + 20);
    chk(n_commit == exp_commit, "R13 abort no commit", n_commit, exp_commit);
    rnd_read(12'h200, 1, "R13 memory unchanged");
    // R11: sequential read across the top of the array
    do_write(12'hFFE, '{8'h11, 8'h22}); wait_idle();
    do_write(12'h000, '{8'h33}); wait_idle();
    rnd_read(12'hFFE, 3, "R11 sequential wrap");
    cur_read(2, "R11 continue after wrap");
    chk(ea.size() == 0, "R5 all expected loads seen", ea.size(), 0);
    chk(n_commit == exp_commit, "R7 final commit count", n_commit, exp_commit);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule